// File: doc/BRIEF.md
# Page-Buffered Write Controller

This block sits behind a serial front end that has already decoded the bus traffic. The front end loads a start address, then sends data bytes one strobe at a time, then sends a commit pulse when the bus transfer ends. The controller gathers the bytes in a 16-entry page buffer. Each entry has a valid flag. The write pointer moves only in its four low bits, so a burst always stays inside one 16-byte page. A burst longer than 16 bytes wraps around and overwrites earlier entries.

A commit starts a timed internal write. The valid buffer entries are copied into a 2K x 8 storage array, which is a plain synchronous RAM inside the block. Busy stays high for a set number of cycles. While busy is high, the controller ignores address loads, strobes and commits. A write-protect input stops every array update. If it is high at commit, the buffered bytes are discarded. A registered read port gives a testbench direct access to the array.

Top module: `page_wr_ctrl`

## Requirements
- R1: After reset, busy is low, the pointer is 0x000 and no buffer entry is valid. Reset does not alter the array.
- R2: An address load sets the pointer to `addr_in`. Each accepted strobe stores `byte_in` in buffer slot `ptr[3:0]` and marks that slot valid. It then raises `ptr[3:0]` by one and keeps `ptr[10:4]` unchanged.
- R3: With more than 16 strobes in one burst, slot `ptr[3:0]` wraps from 15 to 0. Later bytes overwrite earlier ones, and no byte reaches the next page.
- R4: The array does not change before a commit. On a commit with protect low, every valid slot k is written to address `{ptr[10:4], k}`. Invalid slots leave their addresses unchanged.
- R5: Busy rises on the cycle after a commit is sampled. It stays high for exactly `WRITE_CYCLES` cycles.
- R6: Address loads, strobes and commits that arrive while busy is high have no effect. A commit takes priority over a load or strobe in the same cycle, and that load or strobe is dropped.
- R7: All valid flags clear when a write ends. A later commit does not write bytes from an earlier burst again.
- R8: If protect is high at commit, no array location changes and the buffer is discarded. With `BUSY_ON_PROTECT`=1, busy still runs for `WRITE_CYCLES` cycles. With 0, busy stays low. Protect high in any cycle of a write also blocks that cycle's update.
- R9: `dbg_rdata` shows the array byte at the `dbg_raddr` value sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load `addr_in` into the pointer |
| addr_in | input | 11 | Start address of a burst |
| byte_stb | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| commit | input | 1 | End-of-transfer pulse that starts the write |
| wp | input | 1 | Write protect, high blocks array updates |
| busy | output | 1 | Internal write in progress |
| dbg_raddr | input | 11 | Testbench read address |
| dbg_rdata | output | 8 | Testbench read data, one cycle latency |

## Verification
The assertions assume the front end never raises a commit, an address load and a strobe in a way that needs them to be merged. When two arrive together, only the commit is accepted. The assertions also assume `WRITE_CYCLES` is at least 16, so every slot gets its copy cycle.

The stimulus drives one control pulse per cycle on the falling edge. It holds protect steady from the commit until busy falls, except in the directed cases that deliberately send pulses during busy. The array is filled with known data before any check that reads it, so the reference model never compares unwritten locations.

// File: rtl/page_wr_pkg.sv
package page_wr_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wr_state_e;

endpackage

// File: rtl/page_wr_buffer.sv
module page_wr_buffer #(
    parameter int DATA_W = 8,
    parameter int OFFS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OFFS_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int SLOTS = 1 << OFFS_W;

    logic [DATA_W-1:0] data_q [SLOTS];
    logic [DATA_W-1:0] data_d [SLOTS];
    logic [SLOTS-1:0]  valid_q;
    logic [SLOTS-1:0]  valid_d;

    always_comb begin
        data_d  = data_q;
        valid_d = valid_q;
        if (clr) begin
            valid_d = '0;
        end
        if (wr_en) begin
            data_d[wr_idx]  = wr_data;
            valid_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    assign rd_data  = data_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

    // R7
    flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_en) |=> (valid_q == '0));

endmodule

// File: rtl/page_wr_array.sv
module page_wr_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/page_wr_ctrl.sv
module page_wr_ctrl
    import page_wr_pkg::*;
#(
    parameter int ADDR_W          = 11,
    parameter int DATA_W          = 8,
    parameter int OFFS_W          = 4,
    parameter int WRITE_CYCLES    = 24,
    parameter bit BUSY_ON_PROTECT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              commit,
    input  logic              wp,
    output logic              busy,
    input  logic [ADDR_W-1:0] dbg_raddr,
    output logic [DATA_W-1:0] dbg_rdata
);
    localparam int SLOTS  = 1 << OFFS_W;
    localparam int PAGE_W = ADDR_W - OFFS_W;
    localparam int CNT_W  = $clog2(WRITE_CYCLES + SLOTS + 1);

    typedef struct packed {
        wr_state_e         state;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  cnt;
        logic              prot;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              buf_we;
    logic              buf_clr;
    logic [DATA_W-1:0] buf_rdata;
    logic              buf_rvalid;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [PAGE_W-1:0] page_q;

    assign page_q    = ctl_q.ptr[ADDR_W-1:OFFS_W];
    assign arr_waddr = {page_q, ctl_q.cnt[OFFS_W-1:0]};

    always_comb begin
        ctl_d   = ctl_q;
        buf_we  = 1'b0;
        buf_clr = 1'b0;
        arr_we  = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (commit) begin
                    ctl_d.cnt  = '0;
                    ctl_d.prot = wp;
                    if (wp) begin
                        buf_clr = 1'b1;
                    end
                    if (!wp || BUSY_ON_PROTECT) begin
                        ctl_d.state = ST_WRITE;
                    end
                end else if (addr_load) begin
                    ctl_d.ptr = addr_in;
                end else if (byte_stb) begin
                    buf_we    = 1'b1;
                    ctl_d.ptr = {page_q, ctl_q.ptr[OFFS_W-1:0] + 1'b1};
                end
            end
            default: begin
                if ((ctl_q.cnt < CNT_W'(SLOTS)) && buf_rvalid && !ctl_q.prot && !wp) begin
                    arr_we = 1'b1;
                end
                if (ctl_q.cnt == CNT_W'(WRITE_CYCLES - 1)) begin
                    ctl_d.state = ST_IDLE;
                    buf_clr     = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, ptr: '0, cnt: '0, prot: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy = (ctl_q.state == ST_WRITE);

    page_wr_buffer #(
        .DATA_W (DATA_W),
        .OFFS_W (OFFS_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_we),
        .wr_idx   (ctl_q.ptr[OFFS_W-1:0]),
        .wr_data  (byte_in),
        .clr      (buf_clr),
        .rd_idx   (ctl_q.cnt[OFFS_W-1:0]),
        .rd_data  (buf_rdata),
        .rd_valid (buf_rvalid)
    );

    page_wr_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (buf_rdata),
        .raddr (dbg_raddr),
        .rdata (dbg_rdata)
    );

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(ctl_q.cnt) == CNT_W'(WRITE_CYCLES - 1)));

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && byte_stb && !addr_load && !commit) |=>
        ((ctl_q.ptr[ADDR_W-1:OFFS_W] == $past(ctl_q.ptr[ADDR_W-1:OFFS_W])) &&
         (ctl_q.ptr[OFFS_W-1:0] == $past(ctl_q.ptr[OFFS_W-1:0]) + 1'b1)));

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctl_q.ptr));

endmodule

// File: tb/page_wr_ctrl_test.sv
module page_wr_ctrl_test;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int WCYC   = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              addr_load = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              byte_stb = 1'b0;
    logic [DATA_W-1:0] byte_in = '0;
    logic              commit = 1'b0;
    logic              wp = 1'b0;
    logic              busy;
    logic [ADDR_W-1:0] dbg_raddr = '0;
    logic [DATA_W-1:0] dbg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0]  ref_mem [2048];
    logic [7:0]  ref_buf [16];
    logic [15:0] ref_val;
    logic [10:0] ref_ptr;

    always #5 clk = ~clk;

    page_wr_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(4),
        .WRITE_CYCLES(WCYC), .BUSY_ON_PROTECT(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .commit(commit), .wp(wp),
        .busy(busy), .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata)
    );

    function automatic logic [31:0] mk(logic [10:0] a, logic [5:0] n, logic [7:0] s, logic w);
        return {6'd0, w, s, n, a};
    endfunction

    localparam logic [31:0] VEC [8] = '{
        mk(11'h123,  6'd1, 8'h11, 1'b0),
        mk(11'h200, 6'd16, 8'h22, 1'b0),
        mk(11'h35A, 6'd10, 8'h33, 1'b0),
        mk(11'h47C, 6'd20, 8'h44, 1'b0),
        mk(11'h500, 6'd16, 8'h55, 1'b1),
        mk(11'h7F0, 6'd16, 8'h66, 1'b0),
        mk(11'h000,  6'd3, 8'h77, 1'b0),
        mk(11'h6E1, 6'd33, 8'h88, 1'b0)
    };

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load_addr(logic [10:0] a);
        addr_load = 1'b1; addr_in = a;
        @(negedge clk);
        addr_load = 1'b0;
        ref_ptr = a;
    endtask

    task automatic send_byte(logic [7:0] b);
        byte_stb = 1'b1; byte_in = b;
        @(negedge clk);
        byte_stb = 1'b0;
        ref_buf[ref_ptr[3:0]] = b;
        ref_val[ref_ptr[3:0]] = 1'b1;
        ref_ptr = {ref_ptr[10:4], ref_ptr[3:0] + 4'd1};
    endtask

    // inject: pulses a load, strobe and commit during busy (all must be ignored)
    task automatic do_commit(logic w, bit inject, output int cnt);
        wp = w; commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        cnt = 0;
        while (busy === 1'b1) begin
            cnt++;
            if (inject && cnt == 3) begin
                addr_load = 1'b1; addr_in = 11'h300;
            end else if (inject && cnt == 5) begin
                byte_stb = 1'b1; byte_in = 8'hEE;
            end else if (inject && cnt == 7) begin
                commit = 1'b1;
            end
            @(negedge clk);
            addr_load = 1'b0; byte_stb = 1'b0; commit = 1'b0;
        end
        if (!w) begin
            for (int k = 0; k < 16; k++) begin
                if (ref_val[k]) ref_mem[{ref_ptr[10:4], 4'(k)}] = ref_buf[k];
            end
        end
        ref_val = '0;
        wp = 1'b0;
    endtask

    task automatic rd_chk(logic [10:0] a, string tag);
        dbg_raddr = a;
        @(negedge clk);
        chk(dbg_rdata === ref_mem[a], tag, int'(dbg_rdata), int'(ref_mem[a]));
    endtask

    task automatic page_chk(logic [6:0] pg, string tag);
        for (int k = 0; k < 16; k++) rd_chk({pg, 4'(k)}, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int c;
        ref_val = '0; ref_ptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);

        // fill array with known data
        for (int p = 0; p < 128; p++) begin
            load_addr(11'(p * 16));
            for (int i = 0; i < 16; i++) send_byte(8'(p * 16 * 7 + i * 7 + 3));
            do_commit(1'b0, 1'b0, c);
        end

        // vector table: R2 R3 R4 R5 R8
        foreach (VEC[v]) begin
            logic [10:0] a; logic [5:0] n; logic [7:0] s; logic w;
            a = VEC[v][10:0]; n = VEC[v][16:11]; s = VEC[v][24:17]; w = VEC[v][25];
            load_addr(a);
            for (int i = 0; i < int'(n); i++) send_byte(s + 8'(i * 29));
            do_commit(w, 1'b0, c);
            chk(c == WCYC, w ? "R8 busy length protected" : "R5 busy length", c, WCYC);
            page_chk(a[10:4], w ? "R8 protected page" : "R2/R3 page content");
        end

        // R4: array untouched before commit
        load_addr(11'h0A0);
        send_byte(8'hC1);
        send_byte(8'hC2);
        rd_chk(11'h0A0, "R4 before commit");
        rd_chk(11'h0A1, "R4 before commit");
        do_commit(1'b0, 1'b0, c);
        page_chk(7'h0A, "R4 after commit");

        // R6: pulses during busy ignored, pointer keeps its place
        load_addr(11'h2C0);
        for (int i = 0; i < 3; i++) send_byte(8'h90 + 8'(i));
        do_commit(1'b0, 1'b1, c);
        chk(c == WCYC, "R6 busy length with mid-write commit", c, WCYC);
        send_byte(8'h5D);
        do_commit(1'b0, 1'b0, c);
        rd_chk(11'h2C3, "R6 pointer after busy");
        page_chk(7'h2C, "R6 page");
        page_chk(7'h30, "R6 ignored load page");

        // R6: commit beats strobe in same cycle
        load_addr(11'h150);
        byte_stb = 1'b1; byte_in = 8'h77;
        do_commit(1'b0, 1'b0, c);
        byte_stb = 1'b0;
        page_chk(7'h15, "R6 commit priority");

        // R7: flags cleared, earlier burst not rewritten
        load_addr(11'h610);
        send_byte(8'hA1);
        do_commit(1'b0, 1'b0, c);
        load_addr(11'h625);
        send_byte(8'hB2);
        do_commit(1'b0, 1'b0, c);
        page_chk(7'h62, "R7 stale flag");

        // R8: protected commit discards buffer
        load_addr(11'h440);
        send_byte(8'hD4);
        send_byte(8'hD5);
        do_commit(1'b1, 1'b0, c);
        do_commit(1'b0, 1'b0, c);
        chk(c == WCYC, "R8 empty commit busy", c, WCYC);
        page_chk(7'h44, "R8 discard");

        // R1: reset mid-run keeps array, pointer back to zero
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ref_ptr = '0; ref_val = '0;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy after second reset", int'(busy), 0);
        send_byte(8'h3C);
        do_commit(1'b0, 1'b0, c);
        page_chk(7'h00, "R1 pointer zero after reset");

        // R9: full array sweep via read port
        for (int a = 0; a < 2048; a++) rd_chk(11'(a), "R9 sweep");

        finish_run();
    end

endmodule